// File: doc/BRIEF.md
# Burst-Capable Word Store with Split Read and Write Channels

This block is a memory target on a five-channel burst bus. Behind it sits a register-file store of `DEPTH` words of `DATA_W` bits, reset to zero. A master opens a write burst on the write-request channel, streams the beats on the write-beat channel, and collects a single status on the write-status channel. Reads open on the read-request channel and return one beat per word on the read-beat channel, each beat with its own status. Every channel uses its own valid/ready pair, and a transfer happens only on a clock edge where both are high.

Each direction serves one burst at a time. The two directions run independently of each other. Status words echo the request tag. The last read beat is flagged. Byte-lane enables on write beats choose which bytes of a word change. Bad addresses, mismatched beat tags and misplaced last flags are reported with an error status instead of a success status.

Top module: `burst_word_store`

## Requirements
- R1: A transfer happens only on an edge where valid and ready are both high. While `wr_valid` or `rd_valid` is high and its ready is low, the valid stays high and the channel's payload (tag, status, data, last flag) does not change.
- R2: While `rst_n` is low, `wr_valid`, `rd_valid`, `wa_ready`, `wd_ready` and `ra_ready` are all low. Reset clears every word of the store to zero.
- R3: Bit n of `wd_lanes` lets data bits [8n+7:8n] of a beat be stored. Bytes whose lane bit is clear keep their previous value.
- R4: `wr_tag` equals the `wa_tag` of the burst it answers. `rd_tag` equals the `ra_tag` of its burst on every beat.
- R5: A burst has `len`+1 beats. `rd_last` is high on beat `len`+1 and on no other beat. `rd_valid` is low in the cycle after that beat is taken.
- R6: Exactly one write status is returned per burst. `wr_valid` rises in the cycle after the edge that takes beat `len`+1, is low before that, and is low again in the cycle after the status is taken.
- R7: A beat's word index is its byte address shifted right by 2. A beat whose address is at or above `DEPTH`*4 (1024 by default) is out of range. An out-of-range write beat is not stored and makes the burst status SLVERR (2'b10). An out-of-range read beat returns data 0 with status SLVERR. In-range read beats and error-free write bursts return OKAY (2'b00).
- R8: A write beat whose `wd_tag` differs from the burst's `wa_tag` is not stored, and the burst status is SLVERR.
- R9: `wd_last` must be high on beat `len`+1 and low on every other beat. Any other placement makes the burst status SLVERR. The burst still takes exactly `len`+1 beats, and beats that are otherwise valid are stored.
- R10: Burst mode 2'b00 keeps the same word for every beat. Mode 2'b01 steps one word (+4 bytes, word aligned) per beat. Mode 2'b10 steps one word per beat but wraps inside the aligned block of (`len`+1)*4 bytes when `len`+1 is 2, 4, 8 or 16; with any other length it steps like 2'b01. Mode 2'b11 steps like 2'b01.
- R11: Read beats come back in burst order. Each read beat shows every write whose status was taken before the read request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wa_valid | input | 1 | Write request valid |
| wa_ready | output | 1 | Write request ready |
| wa_tag | input | ID_W | Write request tag |
| wa_addr | input | 32 | Write burst start byte address |
| wa_len | input | 4 | Write beats minus one |
| wa_mode | input | 2 | Write burst address mode |
| wd_valid | input | 1 | Write beat valid |
| wd_ready | output | 1 | Write beat ready |
| wd_tag | input | ID_W | Write beat tag, must match the request tag |
| wd_data | input | DATA_W | Write beat data |
| wd_lanes | input | DATA_W/8 | Byte-lane enables of the write beat |
| wd_last | input | 1 | Master's final-beat marker |
| wr_valid | output | 1 | Write status valid |
| wr_ready | input | 1 | Write status ready |
| wr_tag | output | ID_W | Tag of the answered write burst |
| wr_resp | output | 2 | Write burst status |
| ra_valid | input | 1 | Read request valid |
| ra_ready | output | 1 | Read request ready |
| ra_tag | input | ID_W | Read request tag |
| ra_addr | input | 32 | Read burst start byte address |
| ra_len | input | 4 | Read beats minus one |
| ra_mode | input | 2 | Read burst address mode |
| rd_valid | output | 1 | Read beat valid |
| rd_ready | input | 1 | Read beat ready |
| rd_tag | output | ID_W | Tag of the read burst |
| rd_data | output | DATA_W | Read beat data |
| rd_resp | output | 2 | Read beat status |
| rd_last | output | 1 | Final read beat marker |

## Verification
Both request readies are high in every idle cycle. The write status becomes valid one cycle after the edge that takes the final write beat. The first read beat is valid one cycle after the edge that takes the read request, and each further beat follows one cycle after the previous beat is taken. A store write takes effect on the edge that takes its beat. The bench drives and samples on the falling edge only. After each handshake edge it checks the outputs at the very next falling edge against a behavioural model of the store and of the address walk, and it compares every read beat and write status there. Where it holds a ready low on purpose, it also checks that the payload stays the same across the stall.

// File: rtl/bws_pkg.sv
package bws_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  typedef enum logic [1:0] {
    BM_FIXED = 2'b00,
    BM_INCR  = 2'b01,
    BM_WRAP  = 2'b10,
    BM_RSVD  = 2'b11
  } bmode_e;

  // Address of the beat that follows beat address a, for beats of 2**sh bytes.
  function automatic logic [31:0] next_beat_addr(input logic [31:0] a,
                                                 input logic [1:0]  mode,
                                                 input logic [3:0]  len,
                                                 input int unsigned sh);
    logic [31:0] unit, aligned, span, mask;
    logic        pow2;
    unit    = 32'd1 << sh;
    aligned = a & ~(unit - 32'd1);
    span    = ({28'd0, len} + 32'd1) << sh;
    mask    = span - 32'd1;
    pow2    = (len == 4'd1) || (len == 4'd3) || (len == 4'd7) || (len == 4'd15);
    if (mode == BM_FIXED) return a;
    if (mode == BM_WRAP && pow2) return (aligned & ~mask) | ((aligned + unit) & mask);
    return aligned + unit;
  endfunction

  function automatic logic addr_in_range(input logic [31:0] a,
                                         input int unsigned sh,
                                         input int unsigned words);
    return (a >> sh) < 32'(words);
  endfunction

endpackage

// File: rtl/bws_mem.sv
module bws_mem #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  we_lanes,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  r_idx,
  output logic [DATA_W-1:0] r_data
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (we_lanes[l]) cells[w_idx][8*l +: 8] <= w_data[8*l +: 8];
    end
  end

  assign r_data = cells[r_idx];
endmodule

// File: rtl/bws_wr.sv
module bws_wr
  import bws_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int LANES = DATA_W / 8,
  localparam int SH    = $clog2(LANES),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_valid,
  output logic              wa_ready,
  input  logic [ID_W-1:0]   wa_tag,
  input  logic [31:0]       wa_addr,
  input  logic [3:0]        wa_len,
  input  logic [1:0]        wa_mode,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [ID_W-1:0]   wd_tag,
  input  logic [DATA_W-1:0] wd_data,
  input  logic [LANES-1:0]  wd_lanes,
  input  logic              wd_last,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ID_W-1:0]   wr_tag,
  output logic [1:0]        wr_resp,
  output logic [LANES-1:0]  mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [DATA_W-1:0] mem_data,
  output logic              beat_fire,
  output logic              burst_done
);
  typedef enum logic [1:0] {WS_ADDR, WS_DATA, WS_RESP} wr_state_e;

  wr_state_e       st;
  logic [ID_W-1:0] cur_tag;
  logic [31:0]     cur_addr;
  logic [3:0]      cur_len, cnt;
  logic [1:0]      cur_mode;
  logic            err;
  logic            final_beat, beat_ok, last_bad;

  assign wa_ready   = rst_n && (st == WS_ADDR);
  assign wd_ready   = rst_n && (st == WS_DATA);
  assign wr_valid   = (st == WS_RESP);
  assign wr_tag     = cur_tag;
  assign wr_resp    = err ? RESP_SLVERR : RESP_OKAY;

  assign beat_fire  = wd_valid && wd_ready;
  assign final_beat = (cnt == cur_len);
  assign burst_done = beat_fire && final_beat;
  assign beat_ok    = addr_in_range(cur_addr, SH, DEPTH) && (wd_tag == cur_tag);
  assign last_bad   = (wd_last != final_beat);

  assign mem_we   = (beat_fire && beat_ok) ? wd_lanes : '0;
  assign mem_idx  = cur_addr[SH +: IDX_W];
  assign mem_data = wd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= WS_ADDR;
      cur_tag  <= '0;
      cur_addr <= '0;
      cur_len  <= '0;
      cur_mode <= '0;
      cnt      <= '0;
      err      <= 1'b0;
    end else begin
      case (st)
        WS_ADDR: if (wa_valid && wa_ready) begin
          st       <= WS_DATA;
          cur_tag  <= wa_tag;
          cur_addr <= wa_addr;
          cur_len  <= wa_len;
          cur_mode <= wa_mode;
          cnt      <= '0;
          err      <= 1'b0;
        end
        WS_DATA: if (beat_fire) begin
          err <= err || !beat_ok || last_bad;
          if (final_beat) begin
            st <= WS_RESP;
          end else begin
            cur_addr <= next_beat_addr(cur_addr, cur_mode, cur_len, SH);
            cnt      <= cnt + 4'd1;
          end
        end
        WS_RESP: if (wr_ready) st <= WS_ADDR;
        default: st <= WS_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/bws_rd.sv
module bws_rd
  import bws_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int LANES = DATA_W / 8,
  localparam int SH    = $clog2(LANES),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ra_valid,
  output logic              ra_ready,
  input  logic [ID_W-1:0]   ra_tag,
  input  logic [31:0]       ra_addr,
  input  logic [3:0]        ra_len,
  input  logic [1:0]        ra_mode,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ID_W-1:0]   rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_resp,
  output logic              rd_last,
  output logic [IDX_W-1:0]  mem_idx,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              beat_fire
);
  typedef enum logic {RS_ADDR, RS_DATA} rd_state_e;

  rd_state_e        st;
  logic [ID_W-1:0]  cur_tag;
  logic [31:0]      cur_addr, nxt_addr, fetch_addr;
  logic [3:0]       cur_len, cnt;
  logic [1:0]       cur_mode;
  logic [DATA_W-1:0] data_q;
  logic [1:0]       resp_q;
  logic             fetch_ok, final_beat;

  assign ra_ready   = rst_n && (st == RS_ADDR);
  assign rd_valid   = (st == RS_DATA);
  assign rd_tag     = cur_tag;
  assign rd_data    = data_q;
  assign rd_resp    = resp_q;
  assign final_beat = (cnt == cur_len);
  assign rd_last    = final_beat;
  assign beat_fire  = rd_valid && rd_ready;

  // The next beat is fetched one edge ahead, so a presented beat never changes.
  assign nxt_addr   = next_beat_addr(cur_addr, cur_mode, cur_len, SH);
  assign fetch_addr = (st == RS_ADDR) ? ra_addr : nxt_addr;
  assign fetch_ok   = addr_in_range(fetch_addr, SH, DEPTH);
  assign mem_idx    = fetch_addr[SH +: IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RS_ADDR;
      cur_tag  <= '0;
      cur_addr <= '0;
      cur_len  <= '0;
      cur_mode <= '0;
      cnt      <= '0;
      data_q   <= '0;
      resp_q   <= RESP_OKAY;
    end else begin
      case (st)
        RS_ADDR: if (ra_valid && ra_ready) begin
          st       <= RS_DATA;
          cur_tag  <= ra_tag;
          cur_addr <= ra_addr;
          cur_len  <= ra_len;
          cur_mode <= ra_mode;
          cnt      <= '0;
          data_q   <= fetch_ok ? mem_rdata : '0;
          resp_q   <= fetch_ok ? RESP_OKAY : RESP_SLVERR;
        end
        RS_DATA: if (beat_fire) begin
          if (final_beat) begin
            st <= RS_ADDR;
          end else begin
            cur_addr <= nxt_addr;
            cnt      <= cnt + 4'd1;
            data_q   <= fetch_ok ? mem_rdata : '0;
            resp_q   <= fetch_ok ? RESP_OKAY : RESP_SLVERR;
          end
        end
        default: st <= RS_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/burst_word_store.sv
module burst_word_store #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_valid,
  output logic              wa_ready,
  input  logic [ID_W-1:0]   wa_tag,
  input  logic [31:0]       wa_addr,
  input  logic [3:0]        wa_len,
  input  logic [1:0]        wa_mode,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [ID_W-1:0]   wd_tag,
  input  logic [DATA_W-1:0] wd_data,
  input  logic [LANES-1:0]  wd_lanes,
  input  logic              wd_last,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ID_W-1:0]   wr_tag,
  output logic [1:0]        wr_resp,
  input  logic              ra_valid,
  output logic              ra_ready,
  input  logic [ID_W-1:0]   ra_tag,
  input  logic [31:0]       ra_addr,
  input  logic [3:0]        ra_len,
  input  logic [1:0]        ra_mode,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ID_W-1:0]   rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_resp,
  output logic              rd_last
);
  // Named internal events, observed by the bound checker.
  logic              wr_beat_fire, wr_burst_done, rd_beat_fire;
  logic [LANES-1:0]  store_we;
  logic [IDX_W-1:0]  store_widx, store_ridx;
  logic [DATA_W-1:0] store_wdata, store_rdata;

  bws_wr #(.ID_W(ID_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .wa_valid(wa_valid), .wa_ready(wa_ready), .wa_tag(wa_tag), .wa_addr(wa_addr),
    .wa_len(wa_len), .wa_mode(wa_mode),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_tag(wd_tag), .wd_data(wd_data),
    .wd_lanes(wd_lanes), .wd_last(wd_last),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tag(wr_tag), .wr_resp(wr_resp),
    .mem_we(store_we), .mem_idx(store_widx), .mem_data(store_wdata),
    .beat_fire(wr_beat_fire), .burst_done(wr_burst_done)
  );

  bws_rd #(.ID_W(ID_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .ra_valid(ra_valid), .ra_ready(ra_ready), .ra_tag(ra_tag), .ra_addr(ra_addr),
    .ra_len(ra_len), .ra_mode(ra_mode),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_tag(rd_tag), .rd_data(rd_data),
    .rd_resp(rd_resp), .rd_last(rd_last),
    .mem_idx(store_ridx), .mem_rdata(store_rdata), .beat_fire(rd_beat_fire)
  );

  bws_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we_lanes(store_we), .w_idx(store_widx), .w_data(store_wdata),
    .r_idx(store_ridx), .r_data(store_rdata)
  );
endmodule

// File: rtl/bws_chk.sv
module bws_chk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wa_ready,
  input logic              wd_ready,
  input logic              ra_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ID_W-1:0]   wr_tag,
  input logic [1:0]        wr_resp,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ID_W-1:0]   rd_tag,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        rd_resp,
  input logic              rd_last,
  input logic [ID_W-1:0]   wd_tag,
  input logic              wr_beat_fire,
  input logic              wr_burst_done,
  input logic              rd_beat_fire,
  input logic [LANES-1:0]  store_we
);
  a_r2_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !(wr_valid || rd_valid || wa_ready || wd_ready || ra_ready));

  a_r1_wstatus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_tag) && $stable(wr_resp));

  a_r1_rbeat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable({rd_tag, rd_data, rd_resp, rd_last}));

  a_r6_status_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(wr_burst_done));

  a_r5_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat_fire && rd_last |=> !rd_valid);

  a_r8_foreign_tag_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat_fire && (wd_tag != wr_tag) |-> store_we == '0);

  a_r7_range_error_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_resp == 2'b10 |-> rd_data == '0);
endmodule

bind burst_word_store bws_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wa_ready(wa_ready), .wd_ready(wd_ready), .ra_ready(ra_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tag(wr_tag), .wr_resp(wr_resp),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_tag(rd_tag), .rd_data(rd_data),
  .rd_resp(rd_resp), .rd_last(rd_last), .wd_tag(wd_tag),
  .wr_beat_fire(wr_beat_fire), .wr_burst_done(wr_burst_done),
  .rd_beat_fire(rd_beat_fire), .store_we(store_we)
);

// File: tb/burst_word_store_test.sv
module burst_word_store_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wa_valid = 0, wd_valid = 0, wr_ready = 0, ra_valid = 0, rd_ready = 0;
  logic [3:0]  wa_tag = 0, wd_tag = 0, ra_tag = 0, wa_len = 0, ra_len = 0;
  logic [31:0] wa_addr = 0, ra_addr = 0, wd_data = 0;
  logic [1:0]  wa_mode = 0, ra_mode = 0;
  logic [3:0]  wd_lanes = 0;
  logic        wd_last = 0;
  logic        wa_ready, wd_ready, wr_valid, ra_ready, rd_valid, rd_last;
  logic [3:0]  wr_tag, rd_tag;
  logic [1:0]  wr_resp, rd_resp;
  logic [31:0] rd_data;

  burst_word_store uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] model [256];
  logic [31:0] wdat [16];
  logic [3:0]  wstb [16];

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Word visited by beat i of a burst, computed by wrap-around arithmetic.
  function automatic longint widx(input logic [31:0] start, input logic [1:0] mode,
                                  input int len, input int i);
    longint w, base;
    int span;
    w = longint'(start) >> 2;
    span = len + 1;
    if (mode == 2'b00) return w;
    if (mode == 2'b10 && (span == 2 || span == 4 || span == 8 || span == 16)) begin
      base = w - (w % span);
      return base + ((w - base + i) % span);
    end
    return w + i;
  endfunction

  task automatic fill(input int seed, input logic [3:0] lanes);
    for (int i = 0; i < 16; i++) begin
      wdat[i] = 32'h5A000000 ^ (32'(seed) << 12) ^ (32'(i) * 32'h01030507);
      wstb[i] = lanes;
    end
  endtask

  task automatic do_write(input logic [3:0] tag, input logic [31:0] addr,
                          input logic [1:0] mode, input int len,
                          input logic [3:0] dtag, input int lastpos,
                          input logic [1:0] exp_resp, input string req);
    bit ok, err;
    longint w;
    err = 0;
    @(negedge clk);
    wa_valid = 1; wa_tag = tag; wa_addr = addr; wa_mode = mode; wa_len = len[3:0];
    do begin ok = wa_ready; @(negedge clk); end while (!ok);
    wa_valid = 0;
    for (int i = 0; i <= len; i++) begin
      if (i % 2 == 1) begin wd_valid = 0; @(negedge clk); end
      chk("R6", "status early", wr_valid, 0);
      wd_valid = 1; wd_tag = dtag; wd_data = wdat[i]; wd_lanes = wstb[i];
      wd_last = (i == lastpos);
      do begin ok = wd_ready; @(negedge clk); end while (!ok);
      w = widx(addr, mode, len, i);
      if (w >= 256 || dtag != tag) err = 1;
      else for (int l = 0; l < 4; l++)
        if (wstb[i][l]) model[int'(w)][8*l +: 8] = wdat[i][8*l +: 8];
      if ((i == lastpos) != (i == len)) err = 1;
    end
    wd_valid = 0; wd_last = 0;
    for (int s = 0; s < 2; s++) begin
      chk("R6", "status due", wr_valid, 1);
      chk("R1", "status tag held", wr_tag, tag);
      chk("R1", "status held", wr_resp, err ? 2'b10 : 2'b00);
      @(negedge clk);
    end
    chk("R4", "write tag", wr_tag, tag);
    chk(req, "write status", wr_resp, exp_resp);
    wr_ready = 1; @(negedge clk); wr_ready = 0;
    chk("R6", "single status", wr_valid, 0);
  endtask

  task automatic do_read(input logic [3:0] tag, input logic [31:0] addr,
                         input logic [1:0] mode, input int len, input bit stall,
                         input string req);
    bit ok;
    longint w;
    logic [31:0] ed;
    logic [1:0]  er;
    @(negedge clk);
    ra_valid = 1; ra_tag = tag; ra_addr = addr; ra_mode = mode; ra_len = len[3:0];
    do begin ok = ra_ready; @(negedge clk); end while (!ok);
    ra_valid = 0;
    for (int i = 0; i <= len; i++) begin
      w  = widx(addr, mode, len, i);
      ed = (w < 256) ? model[int'(w)] : 32'd0;
      er = (w < 256) ? 2'b00 : 2'b10;
      if (stall && i == 0) begin
        @(negedge clk);
        chk("R1", "beat held valid", rd_valid, 1);
      end
      chk("R1", "beat valid", rd_valid, 1);
      chk(req, "read data", rd_data, ed);
      chk("R7", "read status", rd_resp, er);
      chk("R4", "read tag", rd_tag, tag);
      chk("R5", "last flag", rd_last, (i == len));
      rd_ready = 1; @(negedge clk); rd_ready = 0;
    end
    chk("R5", "idle after last", rd_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    wa_valid = 1; ra_valid = 1;
    repeat (3) @(negedge clk);
    chk("R2", "wr_valid in reset", wr_valid, 0);
    chk("R2", "rd_valid in reset", rd_valid, 0);
    chk("R2", "readies in reset", {wa_ready, wd_ready, ra_ready}, 3'b000);
    wa_valid = 0; ra_valid = 0;
    rst_n = 1;
    @(negedge clk);
    chk("R2", "idle readies", {wa_ready, wd_ready, ra_ready}, 3'b101);
    do_read(4'h1, 32'h0, 2'b01, 3, 0, "R2");                 // cleared store

    fill(1, 4'hF);
    do_write(4'h5, 32'h40, 2'b01, 3, 4'h5, 3, 2'b00, "R7");
    do_read(4'h9, 32'h40, 2'b01, 3, 1, "R11");

    fill(2, 4'h5); wstb[1] = 4'h8;                           // lanes 0,2 then lane 3
    do_write(4'h2, 32'h44, 2'b00, 1, 4'h2, 1, 2'b00, "R3");
    do_read(4'h2, 32'h44, 2'b00, 0, 0, "R3");
    do_read(4'h3, 32'h44, 2'b00, 2, 0, "R10");

    fill(3, 4'hF);
    do_write(4'h7, 32'h88, 2'b10, 3, 4'h7, 3, 2'b00, "R10");
    do_read(4'h7, 32'h80, 2'b01, 3, 0, "R10");
    do_read(4'h6, 32'h8C, 2'b10, 3, 1, "R10");

    fill(4, 4'hF);
    do_write(4'hA, 32'h100, 2'b10, 2, 4'hA, 2, 2'b00, "R10"); // length 3: steps
    do_read(4'hA, 32'h100, 2'b01, 3, 0, "R10");
    do_write(4'hB, 32'h180, 2'b11, 1, 4'hB, 1, 2'b00, "R10"); // mode 11: steps
    do_read(4'hB, 32'h180, 2'b01, 1, 0, "R10");

    fill(5, 4'hF);
    do_write(4'hC, 32'h3FC, 2'b01, 1, 4'hC, 1, 2'b10, "R7");
    do_read(4'hC, 32'h3F8, 2'b01, 2, 0, "R7");
    do_read(4'hD, 32'h800, 2'b00, 0, 0, "R7");

    fill(6, 4'hF);
    do_write(4'h3, 32'h40, 2'b01, 3, 4'h4, 3, 2'b10, "R8");
    do_read(4'h3, 32'h40, 2'b01, 3, 0, "R8");

    fill(7, 4'hF);
    do_write(4'h1, 32'h60, 2'b01, 3, 4'h1, 1, 2'b10, "R9");   // early last
    do_write(4'h1, 32'h70, 2'b01, 3, 4'h1, 99, 2'b10, "R9");  // missing last
    do_read(4'hE, 32'h60, 2'b01, 7, 0, "R9");

    fill(8, 4'hF);
    do_write(4'hF, 32'h200, 2'b01, 15, 4'hF, 15, 2'b00, "R11");
    do_read(4'h0, 32'h224, 2'b10, 15, 1, "R10");
    report();
  end
endmodule